// File: doc/BRIEF.md
# Ordered Store Queue with Fence and Write-Acknowledge Mode

This block sits between an in-order core's load/store request port and a slow memory port. Stores are accepted in a single handshake, parked in a small queue, and retired to memory in the background, oldest first, with one store in flight at a time. Loads do not wait behind parked stores: a load to an address with no queued store goes straight to memory ahead of any older store, which relaxes write-to-read ordering. A load whose address matches a queued store gets the youngest matching queued value back without touching memory, so a core sees its own writes early.

Two controls restore ordering when software needs it. A fence operation holds the core port not-ready until every store accepted before it has been acknowledged by memory. A write-acknowledge mode input makes every store hold the port until its acknowledgement returns, so no store is ever overtaken. An idle output reports that the queue is empty and nothing is in flight.

The core side state machine has five states: CS_READY (port open, operations accepted), CS_LOAD_ISSUE (a memory load is requested, with priority over store retirement), CS_LOAD_WAIT (waiting for load data), CS_FENCE (draining before a fence completes) and CS_ACK (draining after a store in write-acknowledge mode). Transitions: CS_READY to CS_LOAD_ISSUE on an accepted load with no queued match; CS_LOAD_ISSUE to CS_LOAD_WAIT when memory takes the request; CS_LOAD_WAIT to CS_READY on load data; CS_READY to CS_FENCE on an accepted fence with a non-empty queue; CS_READY to CS_ACK on an accepted store in write-acknowledge mode; CS_FENCE and CS_ACK to CS_READY once the queue is empty. The retire machine has DS_IDLE (offers the oldest store when the memory port is not claimed by a load) and DS_WAIT (one store in flight); it moves DS_IDLE to DS_WAIT when memory takes the store and back on the acknowledgement, which also frees the queue entry.

Top module: `store_fence_buffer`

## Requirements
- R1: After reset, idle is 1, core_rsp_valid is 0 and core_ready is 1.
- R2: A store (core_op 2'b01) is accepted in one handshake when the queue is not full; queued stores are written to memory in the order they were accepted, each once.
- R3: With DEPTH stores queued, core_ready is 0 for a store, while a load (core_op 2'b00) is still accepted.
- R4: A load to an address with no queued store is served from memory before an older queued store to another address has been acknowledged, and returns memory's current value.
- R5: A load to an address with queued stores returns the data of the youngest matching store, with core_rsp_valid high in the cycle after the load handshake and no memory access.
- R6: A fence (core_op 2'b10) holds core_ready low after its handshake until all earlier stores have been acknowledged; a fence presented with an empty queue is accepted at once and the port is ready again in the next cycle.
- R7: With wack_mode 1, after a store handshake core_ready stays low until that store's acknowledgement has returned.
- R8: A data store, a fence and a flag store reach memory in that order: data first, then flag.
- R9: idle is 0 from the cycle after a store handshake until the last queued store is acknowledged, and no store request is made while idle is 1.
- R10: Every load produces exactly one core_rsp_valid pulse of one cycle; a memory-served load responds in the cycle after memory returns its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wack_mode | input | 1 | 1: each store holds the port until acknowledged |
| core_valid | input | 1 | Core request valid |
| core_ready | output | 1 | Block can take the presented request |
| core_op | input | 2 | 00 load, 01 store, 10 fence, 11 no effect |
| core_addr | input | AW | Request address |
| core_wdata | input | DW | Store data |
| core_rsp_valid | output | 1 | One-cycle pulse with load data |
| core_rsp_data | output | DW | Load data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 store, 0 load |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory store data |
| mem_ld_valid | input | 1 | Load data returned |
| mem_ld_data | input | DW | Returned load data |
| mem_st_ack | input | 1 | Store acknowledged by memory |
| idle | output | 1 | Queue empty and no store in flight |

## Verification
The checker assumes memory acknowledges a store only after taking one, at most one at a time, and returns load data only for a load it took; it also assumes the core keeps op, address and data steady while valid is high and not yet accepted. The bench memory model always accepts requests, returns load data one cycle later and acknowledges a store a fixed latency after taking it, and the bench tasks only change request fields at falling edges after a handshake. DEPTH must be a power of two of at least two, which the default satisfies.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10,
        OP_NONE  = 2'b11
    } core_op_e;

    typedef enum logic [2:0] {
        CS_READY,
        CS_LOAD_ISSUE,
        CS_LOAD_WAIT,
        CS_FENCE,
        CS_ACK
    } core_state_e;

    typedef enum logic {
        DS_IDLE,
        DS_WAIT
    } drain_state_e;

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] lookup_addr,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full,
    output logic          hit,
    output logic [DW-1:0] hit_data
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [CNT_W-1:0] cnt_q;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];

    // Storage: one slot written per push
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q[g] <= '0;
                    data_q[g] <= '0;
                end else if (push && (tail_q == PTR_W'(g))) begin
                    addr_q[g] <= push_addr;
                    data_q[g] <= push_data;
                end
            end
        end
    endgenerate

    // Valid bits, pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (push) begin
                valid_q[tail_q] <= 1'b1;
                tail_q          <= tail_q + 1'b1;
            end
            if (pop) begin
                valid_q[head_q] <= 1'b0;
                head_q          <= head_q + 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Forwarding search: scan oldest to youngest so the youngest match wins
    always_comb begin
        logic [PTR_W-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        idx      = head_q;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head_q + PTR_W'(i);
            if (valid_q[idx] && (addr_q[idx] == lookup_addr)) begin
                hit      = 1'b1;
                hit_data = data_q[idx];
            end
        end
    end

endmodule

// File: rtl/stbuf_drain.sv
module stbuf_drain
    import stbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic ld_claim,
    input  logic mem_req_ready,
    input  logic mem_st_ack,
    output logic st_req_valid,
    output logic pop
);

    drain_state_e state_q;
    drain_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE: if (!empty && !ld_claim && mem_req_ready) state_d = DS_WAIT;
            DS_WAIT: if (mem_st_ack)                           state_d = DS_IDLE;
            default:                                           state_d = DS_IDLE;
        endcase
    end

    always_comb begin
        st_req_valid = 1'b0;
        pop          = 1'b0;
        unique case (state_q)
            DS_IDLE: st_req_valid = !empty && !ld_claim;
            DS_WAIT: pop          = mem_st_ack;
            default: ;
        endcase
    end

endmodule

// File: rtl/store_fence_buffer.sv
module store_fence_buffer
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wack_mode,
    input  logic          core_valid,
    output logic          core_ready,
    input  logic [1:0]    core_op,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_rsp_valid,
    output logic [DW-1:0] core_rsp_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_ld_valid,
    input  logic [DW-1:0] mem_ld_data,
    input  logic          mem_st_ack,
    output logic          idle
);

    core_state_e   state_q;
    core_state_e   state_d;
    logic [AW-1:0] ld_addr_q;
    logic          rsp_valid_q;
    logic [DW-1:0] rsp_data_q;

    logic          q_empty;
    logic          q_full;
    logic          q_hit;
    logic [DW-1:0] q_hit_data;
    logic [AW-1:0] q_head_addr;
    logic [DW-1:0] q_head_data;
    logic          q_pop;
    logic          st_req_valid;
    logic          ld_claim;
    logic          accept;
    logic          push;
    logic          is_load;
    logic          is_store;
    logic          is_fence;

    assign is_load  = (core_op == OP_LOAD);
    assign is_store = (core_op == OP_STORE);
    assign is_fence = (core_op == OP_FENCE);
    assign accept   = core_valid && core_ready;
    assign push     = accept && is_store;

    stbuf_queue #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_addr   (core_addr),
        .push_data   (core_wdata),
        .pop         (q_pop),
        .lookup_addr (core_addr),
        .head_addr   (q_head_addr),
        .head_data   (q_head_data),
        .empty       (q_empty),
        .full        (q_full),
        .hit         (q_hit),
        .hit_data    (q_hit_data)
    );

    stbuf_drain u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .empty         (q_empty),
        .ld_claim      (ld_claim),
        .mem_req_ready (mem_req_ready),
        .mem_st_ack    (mem_st_ack),
        .st_req_valid  (st_req_valid),
        .pop           (q_pop)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_READY: begin
                if (accept) begin
                    if (is_load && !q_hit)          state_d = CS_LOAD_ISSUE;
                    else if (is_store && wack_mode) state_d = CS_ACK;
                    else if (is_fence && !q_empty)  state_d = CS_FENCE;
                end
            end
            CS_LOAD_ISSUE: if (mem_req_ready) state_d = CS_LOAD_WAIT;
            CS_LOAD_WAIT:  if (mem_ld_valid)  state_d = CS_READY;
            CS_FENCE:      if (q_empty)       state_d = CS_READY;
            CS_ACK:        if (q_empty)       state_d = CS_READY;
            default:                          state_d = CS_READY;
        endcase
    end

    // Outputs of the core state machine
    always_comb begin
        core_ready = 1'b0;
        ld_claim   = 1'b0;
        unique case (state_q)
            CS_READY:      core_ready = is_store ? !q_full : 1'b1;
            CS_LOAD_ISSUE: ld_claim   = 1'b1;
            CS_LOAD_WAIT:  ;
            CS_FENCE:      ;
            CS_ACK:        ;
            default:       ;
        endcase
    end

    // Load address capture and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_addr_q   <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept && is_load) begin
                ld_addr_q <= core_addr;
                if (q_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= q_hit_data;
                end
            end
            if ((state_q == CS_LOAD_WAIT) && mem_ld_valid) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= mem_ld_data;
            end
        end
    end

    // Memory port: a pending load takes the port ahead of store retirement
    assign mem_req_valid  = ld_claim || st_req_valid;
    assign mem_req_we     = !ld_claim;
    assign mem_req_addr   = ld_claim ? ld_addr_q : q_head_addr;
    assign mem_req_wdata  = q_head_data;

    assign core_rsp_valid = rsp_valid_q;
    assign core_rsp_data  = rsp_data_q;
    assign idle           = q_empty;

endmodule

// File: rtl/stbuf_chk.sv
module stbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wack_mode,
    input logic       core_valid,
    input logic       core_ready,
    input logic [1:0] core_op,
    input logic       mem_req_valid,
    input logic       mem_req_we,
    input logic       mem_st_ack,
    input logic       idle,
    input logic       q_full
);

    a_r3_no_store_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && (core_op == 2'b01) && q_full) |-> !core_ready);

    a_r6_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_ready && (core_op == 2'b10) && !idle) |=> !core_ready);

    a_r7_wack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_ready && (core_op == 2'b01) && wack_mode) |=> !core_ready);

    a_r9_no_store_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(mem_req_valid && mem_req_we));

    a_r9_store_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && core_ready && (core_op == 2'b01)) |=> !idle);

    a_r2_ack_only_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        mem_st_ack |-> !idle);

endmodule

bind store_fence_buffer stbuf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wack_mode     (wack_mode),
    .core_valid    (core_valid),
    .core_ready    (core_ready),
    .core_op       (core_op),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_st_ack    (mem_st_ack),
    .idle          (idle),
    .q_full        (q_full)
);

// File: tb/store_fence_buffer_tb.sv
module store_fence_buffer_tb;

    localparam int DEPTH     = 8;
    localparam int AW        = 16;
    localparam int DW        = 32;
    localparam int STORE_LAT = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wack_mode = 1'b0;
    logic          core_valid = 1'b0;
    logic          core_ready;
    logic [1:0]    core_op = 2'b00;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_rsp_valid;
    logic [DW-1:0] core_rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic          mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_ld_valid;
    logic [DW-1:0] mem_ld_data;
    logic          mem_st_ack;
    logic          idle;

    int nchk  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    store_fence_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wack_mode(wack_mode),
        .core_valid(core_valid), .core_ready(core_ready), .core_op(core_op),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_ld_valid(mem_ld_valid),
        .mem_ld_data(mem_ld_data), .mem_st_ack(mem_st_ack), .idle(idle)
    );

    // Behavioural memory: load data after 1 cycle, store ack after STORE_LAT
    logic [DW-1:0] mem [256];
    logic [7:0]    wlog_a [64];
    logic [DW-1:0] wlog_d [64];
    int            wr_cnt;
    logic          st_busy;
    int            st_cnt;
    logic [7:0]    st_a;
    logic [DW-1:0] st_d;

    function automatic logic [DW-1:0] init_val(input logic [7:0] a);
        return DW'(a) ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        mem_ld_valid <= 1'b0;
        mem_st_ack   <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
            wr_cnt  <= 0;
            st_busy <= 1'b0;
            st_cnt  <= 0;
        end else begin
            if (mem_req_valid && mem_req_ready && !mem_req_we) begin
                mem_ld_valid <= 1'b1;
                mem_ld_data  <= mem[mem_req_addr[7:0]];
            end
            if (mem_req_valid && mem_req_ready && mem_req_we) begin
                st_busy <= 1'b1;
                st_cnt  <= STORE_LAT - 1;
                st_a    <= mem_req_addr[7:0];
                st_d    <= mem_req_wdata;
            end else if (st_busy) begin
                if (st_cnt == 0) begin
                    mem[st_a]          <= st_d;
                    wlog_a[wr_cnt % 64] <= st_a;
                    wlog_d[wr_cnt % 64] <= st_d;
                    wr_cnt             <= wr_cnt + 1;
                    mem_st_ack         <= 1'b1;
                    st_busy            <= 1'b0;
                end else begin
                    st_cnt <= st_cnt - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one request; returns the number of cycles it waited for ready.
    // Returns at the falling edge after the handshake.
    task automatic op_go(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output int waited);
        waited = 0;
        @(negedge clk);
        core_valid = 1'b1; core_op = op; core_addr = a; core_wdata = d;
        #1;
        while (!core_ready) begin
            @(negedge clk); #1;
            waited++;
        end
        @(posedge clk);
        @(negedge clk);
        core_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [DW-1:0] d, output bit got);
        got = 1'b0; d = '0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (core_rsp_valid) begin got = 1'b1; d = core_rsp_data; end
            else @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && !idle; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(idle == 1'b1, "R1 idle", DW'(idle), 1);
        check(core_rsp_valid == 1'b0, "R1 rsp_valid", DW'(core_rsp_valid), 0);
        check(core_ready == 1'b1, "R1 ready", DW'(core_ready), 1);
    endtask

    task automatic t_bypass();
        int w; int wc0; logic [DW-1:0] d; bit got;
        op_go(2'b01, 16'h0010, 32'h0000_00AA, w);
        check(idle == 1'b0, "R9 idle low after store", DW'(idle), 0);
        wc0 = wr_cnt;
        op_go(2'b00, 16'h0020, '0, w);
        check(core_rsp_valid == 1'b0, "R10 miss not early", DW'(core_rsp_valid), 0);
        wait_rsp(d, got);
        check(got && d == init_val(8'h20), "R4 bypass load data", d, init_val(8'h20));
        check(wr_cnt == wc0, "R4 load passed older store", DW'(wr_cnt), DW'(wc0));
        check(mem[8'h10] == init_val(8'h10), "R4 memory still stale", mem[8'h10],
              init_val(8'h10));
        @(negedge clk);
        check(core_rsp_valid == 1'b0, "R10 single pulse", DW'(core_rsp_valid), 0);
        wait_idle();
        check(mem[8'h10] == 32'hAA, "R2 store reached memory", mem[8'h10], 32'hAA);
        check(wr_cnt == wc0 + 1, "R2 written once", DW'(wr_cnt), DW'(wc0 + 1));
        check(idle == 1'b1, "R9 idle after drain", DW'(idle), 1);
    endtask

    task automatic t_forward();
        int w; int wc0;
        wc0 = wr_cnt;
        op_go(2'b01, 16'h0040, 32'h1, w);
        op_go(2'b01, 16'h0040, 32'h2, w);
        op_go(2'b01, 16'h0041, 32'h3, w);
        op_go(2'b00, 16'h0040, '0, w);
        check(core_rsp_valid == 1'b1, "R5 forward next cycle", DW'(core_rsp_valid), 1);
        check(core_rsp_data == 32'h2, "R5 youngest match", core_rsp_data, 32'h2);
        @(negedge clk);
        check(core_rsp_valid == 1'b0, "R10 forward pulse", DW'(core_rsp_valid), 0);
        op_go(2'b00, 16'h0041, '0, w);
        check(core_rsp_data == 32'h3 && core_rsp_valid, "R5 other match", core_rsp_data,
              32'h3);
        wait_idle();
        check(mem[8'h40] == 32'h2, "R2 final value", mem[8'h40], 32'h2);
        check(wr_cnt == wc0 + 3, "R5 no extra writes", DW'(wr_cnt), DW'(wc0 + 3));
    endtask

    task automatic t_full();
        int w; int wc0; logic [DW-1:0] d; bit got; bit order_ok;
        wc0 = wr_cnt;
        for (int i = 0; i < DEPTH; i++) op_go(2'b01, AW'(16'h0050 + i), DW'(100 + i), w);
        @(negedge clk);
        core_valid = 1'b1; core_op = 2'b01; core_addr = 16'h0058; core_wdata = 32'h9;
        #1;
        check(core_ready == 1'b0, "R3 store held when full", DW'(core_ready), 0);
        core_op = 2'b00; core_addr = 16'h0060;
        #1;
        check(core_ready == 1'b1, "R3 load passes when full", DW'(core_ready), 1);
        @(posedge clk);
        @(negedge clk);
        core_valid = 1'b0;
        wait_rsp(d, got);
        check(got && d == init_val(8'h60), "R3 load data when full", d, init_val(8'h60));
        wait_idle();
        order_ok = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            if (wlog_a[(wc0 + i) % 64] != 8'(8'h50 + i)) order_ok = 1'b0;
        check(order_ok, "R2 FIFO retire order", DW'(order_ok), 1);
    endtask

    task automatic t_fence();
        int w; int wc0;
        wc0 = wr_cnt;
        op_go(2'b01, 16'h0030, 32'h11, w);
        op_go(2'b10, '0, '0, w);
        check(w == 0, "R6 fence accepted", DW'(w), 0);
        op_go(2'b01, 16'h0031, 32'h1, w);
        check(w > 10, "R6 port held during drain", DW'(w), STORE_LAT);
        check(wr_cnt == wc0 + 1 && mem[8'h30] == 32'h11, "R6 data acked before flag",
              DW'(wr_cnt), DW'(wc0 + 1));
        wait_idle();
        check(wlog_a[wc0 % 64] == 8'h30 && wlog_a[(wc0 + 1) % 64] == 8'h31,
              "R8 data then flag", DW'(wlog_a[(wc0 + 1) % 64]), 32'h31);
        op_go(2'b10, '0, '0, w);
        check(w == 0, "R6 empty fence at once", DW'(w), 0);
        core_op = 2'b00;
        #1;
        check(core_ready == 1'b1, "R6 ready after empty fence", DW'(core_ready), 1);
    endtask

    task automatic t_wack();
        int w; int wc0; logic [DW-1:0] d; bit got;
        wack_mode = 1'b1;
        wc0 = wr_cnt;
        op_go(2'b01, 16'h0070, 32'h77, w);
        op_go(2'b00, 16'h0070, '0, w);
        check(w > 10, "R7 held until ack", DW'(w), STORE_LAT);
        check(wr_cnt == wc0 + 1, "R7 ack before next op", DW'(wr_cnt), DW'(wc0 + 1));
        wait_rsp(d, got);
        check(got && d == 32'h77, "R7 load sees acked store", d, 32'h77);
        wack_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_forward();
        t_full();
        t_fence();
        t_wack();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule